// File: doc/BRIEF.md
# Look-Ahead First-Order Recursive Low-Pass Filter

This block smooths a stream of signed fixed-point samples with the single-pole recursion y[n+1] = a·y[n] + b·x[n]. It is built in an unrolled form, y[n+2] = a²·y[n] + ab·x[n] + b·x[n+1], so that the loop from the filter state back to itself passes through two registers instead of one. The multiply by a² and the following add then each get a full clock period. The two input-side terms, b·x[n] and ab·x[n-1], have no feedback. They are formed in a pipelined feed-forward stage, and the result is added to the delayed feedback product.

The coefficients a and b are elaboration-time parameters in signed Q1.15. The block forms a² and ab when it is elaborated and rounds both to Q1.15. Samples enter with a valid strobe and may arrive back-to-back or with idle cycles between them. Each accepted sample produces exactly one output sample after a fixed latency. The internal state carries 15 fraction bits and 16 guard bits above the sample width. The output is rounded and saturated back to the sample width.

Top module: `iir_lookahead`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `out_valid` to 0 and `out_data` to 0 from that edge on.
- R2: A sample presented with `in_valid` high at rising edge k produces `out_valid` high for exactly one cycle, following edge k+3. The latency is 4 cycles, with one output per accepted input.
- R3: With a = b = 0.5 (Q1.15 value 16384), an impulse of 1000 followed by zeros yields 500, 250, 125, 63, 31, 16. These are the one-step recursion values rounded half up.
- R4: The state Y is held in units of 2^-15 sample LSB, on DATA_W+16+15 bits. Each accepted sample x[n] updates Y[n+1] = P + B·x[n] + AB·x[n-1], where P = floor((A2·Y[n-1] + 2^14) / 2^15), the term is saturated to the state width, and x[-1] = Y[-1] = Y[0] = 0.
- R5: A2 and AB are the Q1.15 products a·a and a·b, each computed as floor((p + 2^14) / 2^15) and clamped to [-32768, 32767].
- R6: Each output sample is floor((Y + 2^14) / 2^15), saturated to [-2^(DATA_W-1), 2^(DATA_W-1)-1].
- R7: Cycles with `in_valid` low leave the filter state unchanged. The output sequence depends only on the accepted samples, not on the idle cycles between them.
- R8: While `out_valid` is low, `out_data` keeps the last value it held.
- R9: A reset during a stream discards the samples still in flight and clears the input-delay and feedback registers. The next impulse response is identical to the one seen after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a new input sample in this cycle |
| in_data | input | DATA_W | Input sample, signed two's complement |
| out_valid | output | 1 | Marks a new filtered sample, one-cycle pulse |
| out_data | output | DATA_W | Filtered sample, signed, rounded and saturated |

## Verification
The bench builds two instances. The first uses a = b = 0.5. Here a² and ab are exact in Q1.15, so the look-ahead output has to reproduce the hand-computed one-step impulse response. The second uses a = 30721/32768 and b = 32767/32768. With these values a² needs rounding: truncating it would move the third impulse output from 28800 to 28799. The DC gain near 16 also drives a 20000-amplitude step into both output saturation limits. Both instances are compared against an independent integer model of the quantised recursion. The streams are sent back-to-back, with idle gaps, and with a reset while samples are still in flight.

// File: rtl/iir_la_pkg.sv
package iir_la_pkg;

    // Q-format product of two coefficients, rounded half up and clamped
    // to the coefficient range.
    function automatic int coef_mul_q(input int lhs, input int rhs, input int frac);
        longint lim;
        longint prod;
        lim  = longint'(1) <<< frac;
        prod = (longint'(lhs) * longint'(rhs) + (lim >>> 1)) >>> frac;
        if (prod > lim - 1) begin
            prod = lim - 1;
        end else if (prod < -lim) begin
            prod = -lim;
        end
        return int'(prod);
    endfunction

    // Guard bits kept above the sample width in the recursive state.
    localparam int GUARD_BITS = 16;

endpackage

// File: rtl/iir_la_feedfwd.sv
module iir_la_feedfwd #(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int FF_W    = DATA_W + COEF_W + 1,
    parameter int COEF_B  = 16384,
    parameter int COEF_AB = 8192
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     ff_vld,
    output logic signed [FF_W-1:0]   ff_sum
);

    localparam logic signed [COEF_W-1:0] B_V  = COEF_B[COEF_W-1:0];
    localparam logic signed [COEF_W-1:0] AB_V = COEF_AB[COEF_W-1:0];

    typedef struct packed {
        logic                     cap_v;
        logic signed [DATA_W-1:0] cap_x;
        logic signed [DATA_W-1:0] hist_x;
        logic                     sum_v;
        logic signed [FF_W-1:0]   sum;
    } ff_state_t;

    ff_state_t st_d, st_q;
    logic signed [FF_W-1:0] term_new;
    logic signed [FF_W-1:0] term_old;

    always_comb begin
        st_d     = st_q;
        term_new = FF_W'(B_V) * FF_W'($signed(st_q.cap_x));
        term_old = FF_W'(AB_V) * FF_W'($signed(st_q.hist_x));

        // stage 1: capture the incoming sample
        st_d.cap_v = in_valid;
        if (in_valid) begin
            st_d.cap_x = in_data;
        end

        // stage 2: b*x[n] + ab*x[n-1], then shift the sample history
        st_d.sum_v = st_q.cap_v;
        if (st_q.cap_v) begin
            st_d.sum    = term_new + term_old;
            st_d.hist_x = st_q.cap_x;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ff_vld = st_q.sum_v;
    assign ff_sum = st_q.sum;

endmodule

// File: rtl/iir_la_feedback.sv
module iir_la_feedback #(
    parameter int ACC_W    = 47,
    parameter int FF_W     = 33,
    parameter int COEF_W   = 16,
    parameter int COEF_A2  = 8192
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ff_vld,
    input  logic signed [FF_W-1:0]  ff_sum,
    output logic                    fb_vld,
    output logic signed [ACC_W-1:0] fb_y
);

    localparam int COEF_FRAC = COEF_W - 1;
    localparam int PW        = ACC_W + COEF_FRAC;
    localparam logic signed [COEF_W-1:0] A2_V  = COEF_A2[COEF_W-1:0];
    localparam logic signed [PW-1:0]     HALF  = PW'(1) <<< (COEF_FRAC - 1);
    localparam logic signed [ACC_W-1:0]  Y_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0]  Y_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic                    vld;
        logic signed [ACC_W-1:0] y;     // y[n], newest state
        logic signed [ACC_W-1:0] prod;  // round(a^2 * y[n-1]), second loop register
    } fb_state_t;

    fb_state_t st_d, st_q;
    logic signed [ACC_W:0]   sum_w;
    logic signed [ACC_W-1:0] sum_sat;
    logic signed [PW-1:0]    mul_w;
    logic signed [PW-1:0]    mul_rnd;
    logic signed [PW-1:0]    mul_shift;
    logic                    unused_mul_hi;

    always_comb begin
        st_d = st_q;

        // adder half of the loop: delayed product plus feed-forward term
        sum_w = (ACC_W+1)'($signed(st_q.prod)) + (ACC_W+1)'(ff_sum);
        if (sum_w[ACC_W] != sum_w[ACC_W-1]) begin
            sum_sat = sum_w[ACC_W] ? Y_MIN : Y_MAX;
        end else begin
            sum_sat = sum_w[ACC_W-1:0];
        end

        // multiplier half of the loop: a^2 * newest state, rounded half up
        mul_w     = PW'(A2_V) * PW'($signed(st_q.y));
        mul_rnd   = mul_w + HALF;
        mul_shift = mul_rnd >>> COEF_FRAC;

        st_d.vld = ff_vld;
        if (ff_vld) begin
            st_d.y    = sum_sat;
            st_d.prod = mul_shift[ACC_W-1:0];
        end
    end

    assign unused_mul_hi = ^mul_shift[PW-1:ACC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_vld = st_q.vld;
    assign fb_y   = st_q.y;

endmodule

// File: rtl/iir_la_outsat.sv
module iir_la_outsat #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 47,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fb_vld,
    input  logic signed [ACC_W-1:0]  fb_y,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int COEF_FRAC = COEF_W - 1;
    localparam int RW        = ACC_W + 1;
    localparam int HI_W      = RW - DATA_W + 1;
    localparam logic signed [RW-1:0]     HALF  = RW'(1) <<< (COEF_FRAC - 1);
    localparam logic signed [DATA_W-1:0] O_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] O_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic                     vld;
        logic signed [DATA_W-1:0] data;
    } out_state_t;

    out_state_t st_d, st_q;
    logic signed [RW-1:0]     rnd_w;
    logic signed [RW-1:0]     shifted;
    logic        [HI_W-1:0]   hi_bits;
    logic signed [DATA_W-1:0] clipped;

    always_comb begin
        st_d    = st_q;
        rnd_w   = RW'(fb_y) + HALF;
        shifted = rnd_w >>> COEF_FRAC;
        hi_bits = shifted[RW-1:DATA_W-1];
        if ((&hi_bits) || !(|hi_bits)) begin
            clipped = shifted[DATA_W-1:0];
        end else begin
            clipped = shifted[RW-1] ? O_MIN : O_MAX;
        end

        st_d.vld = fb_vld;
        if (fb_vld) begin
            st_d.data = clipped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

endmodule

// File: rtl/iir_lookahead.sv
module iir_lookahead #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int COEF_A = 16384,
    parameter int COEF_B = 16384
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    import iir_la_pkg::*;

    localparam int COEF_FRAC = COEF_W - 1;
    localparam int ACC_W     = DATA_W + GUARD_BITS + COEF_FRAC;
    localparam int FF_W      = DATA_W + COEF_W + 1;
    localparam int K_A2      = coef_mul_q(COEF_A, COEF_A, COEF_FRAC);
    localparam int K_AB      = coef_mul_q(COEF_A, COEF_B, COEF_FRAC);

    logic                    ff_vld;
    logic signed [FF_W-1:0]  ff_sum;
    logic                    fb_vld;
    logic signed [ACC_W-1:0] fb_y;

    iir_la_feedfwd #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FF_W   (FF_W),
        .COEF_B (COEF_B),
        .COEF_AB(K_AB)
    ) u_ff (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_data (in_data),
        .ff_vld  (ff_vld),
        .ff_sum  (ff_sum)
    );

    iir_la_feedback #(
        .ACC_W  (ACC_W),
        .FF_W   (FF_W),
        .COEF_W (COEF_W),
        .COEF_A2(K_A2)
    ) u_fb (
        .clk   (clk),
        .rst   (rst),
        .ff_vld(ff_vld),
        .ff_sum(ff_sum),
        .fb_vld(fb_vld),
        .fb_y  (fb_y)
    );

    iir_la_outsat #(
        .DATA_W(DATA_W),
        .ACC_W (ACC_W),
        .COEF_W(COEF_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .fb_vld   (fb_vld),
        .fb_y     (fb_y),
        .out_valid(out_valid),
        .out_data (out_data)
    );

endmodule

// File: rtl/iir_lookahead_chk.sv
module iir_lookahead_chk #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 47
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              ff_vld,
    input logic [ACC_W-1:0]  fb_y
);

    logic [2:0] age_q;
    logic       rst_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end

    // R1: the cycle after a reset edge shows an empty, zeroed output
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            a_r1_reset_clear: assert (!out_valid && out_data == '0)
                else $error("R1: output not cleared after reset");
        end
    end

    // R2: every accepted sample shows up four cycles later, and only then
    a_r2_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd4) |-> (out_valid == $past(in_valid, 4)))
        else $error("R2: output strobe does not follow input strobe by 4 cycles");

    // R7: the recursive state moves only when the feed-forward stage delivers
    a_r7_idle_state: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd1 && !$past(ff_vld)) |-> $stable(fb_y))
        else $error("R7: filter state changed without a sample");

    // R8: output data holds between valid pulses
    a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd1 && !out_valid) |-> $stable(out_data))
        else $error("R8: output data moved without a valid pulse");

endmodule

bind iir_lookahead iir_lookahead_chk #(
    .DATA_W(DATA_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_data (out_data),
    .ff_vld   (ff_vld),
    .fb_y     (fb_y)
);

// File: tb/tb_iir_lookahead.sv
`timescale 1ns/1ps
module tb_iir_lookahead;

    localparam int  DATA_W = 16;
    localparam int  COEF_W = 16;
    localparam int  ACC_W  = DATA_W + 16 + 15;
    localparam int  A0 = 16384, B0 = 16384;
    localparam int  A1 = 30721, B1 = 32767;
    localparam longint Y_LIM = longint'(1) <<< (ACC_W - 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic v0 = 1'b0, v1 = 1'b0;
    logic signed [DATA_W-1:0] x0 = '0, x1 = '0;
    logic ov0, ov1;
    logic signed [DATA_W-1:0] y0, y1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int got0[$], got1[$], exp0[$], exp1[$];
    longint m_xp[2], m_y[2], m_p[2], m_a2[2], m_ab[2], m_b[2];

    iir_lookahead #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_A(A0), .COEF_B(B0)) dut (
        .clk(clk), .rst(rst), .in_valid(v0), .in_data(x0), .out_valid(ov0), .out_data(y0));

    iir_lookahead #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_A(A1), .COEF_B(B1)) dut_b (
        .clk(clk), .rst(rst), .in_valid(v1), .in_data(x1), .out_valid(ov1), .out_data(y1));

    always @(negedge clk) begin
        if (!rst) begin
            if (ov0) got0.push_back(int'(y0));
            if (ov1) got1.push_back(int'(y1));
        end
    end

    function automatic longint coef_q(longint a, longint b);
        longint p;
        p = (a * b + 16384) >>> 15;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return p;
    endfunction

    function automatic int out_q(longint y);
        longint r;
        r = (y + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic model_clear();
        for (int d = 0; d < 2; d++) begin
            m_xp[d] = 0; m_y[d] = 0; m_p[d] = 0;
        end
        m_b[0] = B0; m_a2[0] = coef_q(A0, A0); m_ab[0] = coef_q(A0, B0);
        m_b[1] = B1; m_a2[1] = coef_q(A1, A1); m_ab[1] = coef_q(A1, B1);
        got0.delete(); got1.delete(); exp0.delete(); exp1.delete();
    endtask

    task automatic model_step(int d, int x);
        longint nw;
        nw = m_p[d] + m_b[d] * x + m_ab[d] * m_xp[d];
        if (nw > Y_LIM - 1) nw = Y_LIM - 1;
        if (nw < -Y_LIM) nw = -Y_LIM;
        m_p[d]  = (m_a2[d] * m_y[d] + 16384) >>> 15;
        m_y[d]  = nw;
        m_xp[d] = x;
        if (d == 0) exp0.push_back(out_q(nw));
        else        exp1.push_back(out_q(nw));
    endtask

    task automatic send(int d, int x);
        if (d == 0) begin v0 = 1'b1; x0 = DATA_W'(x); end
        else        begin v1 = 1'b1; x1 = DATA_W'(x); end
        model_step(d, x);
        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
    endtask

    task automatic reset_all();
        rst = 1'b1; v0 = 1'b0; v1 = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic drain_compare(string req);
        repeat (8) @(negedge clk);
        check_eq(req, "dut output count", got0.size(), exp0.size());
        for (int i = 0; i < got0.size() && i < exp0.size(); i++)
            check_eq(req, $sformatf("dut sample %0d", i), got0[i], exp0[i]);
        check_eq(req, "dut_b output count", got1.size(), exp1.size());
        for (int i = 0; i < got1.size() && i < exp1.size(); i++)
            check_eq(req, $sformatf("dut_b sample %0d", i), got1[i], exp1[i]);
        got0.delete(); got1.delete(); exp0.delete(); exp1.delete();
    endtask

    task automatic impulse_literal(string req);
        int want[6] = '{500, 250, 125, 63, 31, 16};
        send(0, 1000);
        for (int i = 0; i < 5; i++) send(0, 0);
        repeat (8) @(negedge clk);
        check_eq(req, "impulse output count", got0.size(), 6);
        for (int i = 0; i < 6 && i < got0.size(); i++)
            check_eq(req, $sformatf("impulse sample %0d", i), got0[i], want[i]);
        got0.delete(); exp0.delete();
    endtask

    // R1: outputs empty and zero after reset
    task automatic test_reset_state();
        reset_all();
        check_eq("R1", "dut out_valid", ov0, 0);
        check_eq("R1", "dut out_data", y0, 0);
        check_eq("R1", "dut_b out_valid", ov1, 0);
        check_eq("R1", "dut_b out_data", y1, 0);
    endtask

    // R2: four-cycle latency, single pulse
    task automatic test_latency();
        int cnt = 0;
        int pulses = 0;
        reset_all();
        v0 = 1'b1; x0 = 16'sd1000;
        while (cnt < 12 && !ov0) begin
            @(posedge clk); cnt++;
            @(negedge clk); v0 = 1'b0;
        end
        check_eq("R2", "cycles to out_valid", cnt, 4);
        for (int i = 0; i < 6; i++) begin
            if (ov0) pulses++;
            @(negedge clk);
        end
        check_eq("R2", "valid pulse count", pulses, 1);
    endtask

    // R3: one-step recursion values for a = b = 0.5
    task automatic test_impulse();
        reset_all();
        impulse_literal("R3");
    endtask

    // R4: random streams against the quantised model
    task automatic test_random();
        reset_all();
        for (int i = 0; i < 40; i++) begin
            send(0, int'($urandom_range(16000)) - 8000);
        end
        for (int i = 0; i < 40; i++) begin
            send(1, int'($urandom_range(2000)) - 1000);
        end
        drain_compare("R4");
    endtask

    // R5: rounded a^2 (28802, truncation would give 28801) shows in the third output
    task automatic test_coef();
        reset_all();
        send(1, 32767);
        for (int i = 0; i < 3; i++) send(1, 0);
        repeat (8) @(negedge clk);
        check_eq("R5", "dut_b impulse count", got1.size(), 4);
        if (got1.size() >= 3) begin
            check_eq("R5", "b*x term", got1[0], 32766);
            check_eq("R5", "ab*x term", got1[1], 30719);
            check_eq("R5", "a^2*y term", got1[2], 28800);
        end
        drain_compare("R5");
    endtask

    // R6: gain-16 filter clips at both rails
    task automatic test_saturation();
        reset_all();
        for (int i = 0; i < 80; i++) send(1, 20000);
        repeat (6) @(negedge clk);
        check_eq("R6", "positive rail", y1, 32767);
        for (int i = 0; i < 80; i++) send(1, -20000);
        repeat (6) @(negedge clk);
        check_eq("R6", "negative rail", y1, -32768);
        drain_compare("R6");
    endtask

    // R7, R8: idle gaps do not disturb the result, output holds between pulses
    task automatic test_gaps();
        int seq[30];
        for (int i = 0; i < 30; i++) seq[i] = int'($urandom_range(20000)) - 10000;
        reset_all();
        for (int i = 0; i < 30; i++) send(0, seq[i]);
        drain_compare("R7");
        reset_all();
        for (int i = 0; i < 30; i++) begin
            send(0, seq[i]);
            repeat (i % 4) @(negedge clk);
        end
        repeat (12) @(negedge clk);
        check_eq("R8", "held output after idle", y0, exp0[exp0.size() - 1]);
        drain_compare("R7");
    endtask

    // R9: reset with samples in flight, then fresh impulse response
    task automatic test_reset_mid();
        reset_all();
        for (int i = 0; i < 10; i++) begin
            v1 = 1'b1; x1 = 16'sd12000;
            send(0, 9000 - i * 100);
        end
        send(0, 7000);
        reset_all();
        check_eq("R9", "out_valid after mid-stream reset", ov0, 0);
        check_eq("R9", "out_data after mid-stream reset", y0, 0);
        impulse_literal("R9");
    endtask

    initial begin
        model_clear();
        test_reset_state();
        test_latency();
        test_impulse();
        test_random();
        test_coef();
        test_saturation();
        test_gaps();
        test_reset_mid();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule